// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block adds or subtracts two two's-complement operands of a configurable width (32 bits by default). A single control input chooses the operation. When it is high, the second operand is inverted bit by bit and the carry into the lowest bit is forced to one, so the same ripple chain of full adders gives `A - B`. Each stage computes its sum bit as the exclusive-or of its three inputs and its carry out as their majority.

From the sum and the carries, the block derives four condition flags: zero, negative, carry and signed overflow. It also decodes ten comparison predicates from those flags, six signed and four unsigned. A datapath that needs to compare two values runs a subtraction and reads the predicate it wants. During an addition the predicates are still driven by the same formulas, but they only have a meaning for a subtraction.

The arithmetic is combinational. A single register stage on the outputs gives one clock of latency and a clean sampling point, and it is cleared by an active-low synchronous reset.

Top module: `addsub_flags_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, every output is registered as zero.
- R2: Outputs change only at a rising edge of `clk`, and they show the function of the inputs sampled at the previous rising edge (one cycle of latency).
- R3: `result` equals `op_a + op_b` modulo 2^WIDTH when `sub_en` = 0, and `op_a + ~op_b + 1` (that is `op_a - op_b`) modulo 2^WIDTH when `sub_en` = 1.
- R4: `flag_z` is 1 exactly when every bit of `result` is 0.
- R5: `flag_n` equals bit WIDTH-1 of `result`.
- R6: `flag_c` is the carry out of the most significant stage. For an addition it is the unsigned overflow. For a subtraction it is 1 exactly when `op_a >= op_b` unsigned.
- R7: `flag_v` is 1 when the exact signed sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This equals the carry into the most significant stage xor the carry out of it.
- R8: With `sub_en` = 1, the signed predicates compare the operands as two's-complement numbers: `cmp_lt`, `cmp_le`, `cmp_eq`, `cmp_ne`, `cmp_ge`, `cmp_gt`. They are decoded as lt = N^V, le = Z|(N^V), eq = Z, ne = ~Z, ge = ~(N^V), gt = ~(Z|(N^V)). Exactly one of lt, eq and gt is 1.
- R9: With `sub_en` = 1, the unsigned predicates compare the operands as unsigned numbers: `cmp_ltu` = ~C, `cmp_leu` = ~C|Z, `cmp_geu` = C, `cmp_gtu` = ~(~C|Z).
- R10: With `sub_en` = 0, all ten predicates are still driven by the formulas of R8 and R9, applied to the addition's own flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| result | output | WIDTH | Registered sum or difference |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry out of the top stage |
| flag_v | output | 1 | Signed overflow |
| cmp_lt | output | 1 | Signed less than |
| cmp_le | output | 1 | Signed less or equal |
| cmp_eq | output | 1 | Equal |
| cmp_ne | output | 1 | Not equal |
| cmp_ge | output | 1 | Signed greater or equal |
| cmp_gt | output | 1 | Signed greater than |
| cmp_ltu | output | 1 | Unsigned less than |
| cmp_leu | output | 1 | Unsigned less or equal |
| cmp_geu | output | 1 | Unsigned greater or equal |
| cmp_gtu | output | 1 | Unsigned greater than |

## Verification
The bench targets the full-length ripple case, all ones plus one. A design with a broken link anywhere in the carry chain would leave a stray one in the result and miss both Z and C. It also drives 1 + (-1), where a design that loses the top carry reports C = 0, and the most negative value minus one, where an overflow detector that looks only at the result sign misses V and inverts the signed less-than answer. A second instance, 4 bits wide, is checked on every operand pair in both modes against integer arithmetic. This exposes a swapped signed/unsigned decode, an inverted C for subtraction, or a carry-in that ignores the subtract input.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } cc_flags_t;

    typedef struct packed {
        logic lt;
        logic le;
        logic eq;
        logic ne;
        logic ge;
        logic gt;
        logic ltu;
        logic leu;
        logic geu;
        logic gtu;
    } cmp_set_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    always_comb begin
        s_o  = a_i ^ b_i ^ ci_i;
        co_o = (a_i & b_i) | (a_i & ci_i) | (b_i & ci_i);
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_msb_in_o,
    output logic             c_out_o
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        fa_cell u_fa (
            .a_i  (a_i[i]),
            .b_i  (b_i[i]),
            .ci_i (carry[i]),
            .s_o  (sum_o[i]),
            .co_o (carry[i+1])
        );
    end

    assign c_msb_in_o = carry[WIDTH-1];
    assign c_out_o    = carry[WIDTH];
endmodule

// File: rtl/cc_decode.sv
module cc_decode
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum_i,
    input  logic             c_msb_in_i,
    input  logic             c_out_i,
    output cc_flags_t        flags_o,
    output cmp_set_t         cmps_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic s_less;
    logic u_leq;

    always_comb begin
        flags_o.z = ~|sum_i;
        flags_o.n = sum_i[MSB];
        flags_o.c = c_out_i;
        flags_o.v = c_msb_in_i ^ c_out_i;

        s_less = flags_o.n ^ flags_o.v;
        u_leq  = ~flags_o.c | flags_o.z;

        cmps_o.lt  = s_less;
        cmps_o.le  = flags_o.z | s_less;
        cmps_o.eq  = flags_o.z;
        cmps_o.ne  = ~flags_o.z;
        cmps_o.ge  = ~s_less;
        cmps_o.gt  = ~(flags_o.z | s_less);
        cmps_o.ltu = ~flags_o.c;
        cmps_o.leu = u_leq;
        cmps_o.geu = flags_o.c;
        cmps_o.gtu = ~u_leq;
    end
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_en,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v,
    output logic             cmp_lt,
    output logic             cmp_le,
    output logic             cmp_eq,
    output logic             cmp_ne,
    output logic             cmp_ge,
    output logic             cmp_gt,
    output logic             cmp_ltu,
    output logic             cmp_leu,
    output logic             cmp_geu,
    output logic             cmp_gtu
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum_w;
    logic             c_into_msb;
    logic             c_out_w;
    cc_flags_t        flags_w;
    cmp_set_t         cmps_w;

    logic [WIDTH-1:0] result_q;
    cc_flags_t        flags_q;
    cmp_set_t         cmps_q;

    // Conditional inversion of B; the carry-in carries the +1.
    always_comb b_eff = op_b ^ {WIDTH{sub_en}};

    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i        (op_a),
        .b_i        (b_eff),
        .cin_i      (sub_en),
        .sum_o      (sum_w),
        .c_msb_in_o (c_into_msb),
        .c_out_o    (c_out_w)
    );

    cc_decode #(.WIDTH(WIDTH)) u_dec (
        .sum_i      (sum_w),
        .c_msb_in_i (c_into_msb),
        .c_out_i    (c_out_w),
        .flags_o    (flags_w),
        .cmps_o     (cmps_w)
    );

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
            cmps_q   <= '0;
        end else begin
            result_q <= sum_w;
            flags_q  <= flags_w;
            cmps_q   <= cmps_w;
        end
    end

    assign result  = result_q;
    assign flag_z  = flags_q.z;
    assign flag_n  = flags_q.n;
    assign flag_c  = flags_q.c;
    assign flag_v  = flags_q.v;
    assign cmp_lt  = cmps_q.lt;
    assign cmp_le  = cmps_q.le;
    assign cmp_eq  = cmps_q.eq;
    assign cmp_ne  = cmps_q.ne;
    assign cmp_ge  = cmps_q.ge;
    assign cmp_gt  = cmps_q.gt;
    assign cmp_ltu = cmps_q.ltu;
    assign cmp_leu = cmps_q.leu;
    assign cmp_geu = cmps_q.geu;
    assign cmp_gtu = cmps_q.gtu;

    // R3
    sum_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> result == ($past(sub_en) ? $past(op_a) - $past(op_b)
                                                  : $past(op_a) + $past(op_b)));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> flag_z == (result == '0));

    // R6
    carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> flag_c == ($past(sub_en)
            ? ($past(op_a) >= $past(op_b))
            : (({1'b0, $past(op_a)} + {1'b0, $past(op_b)}) > {1'b0, {WIDTH{1'b1}}})));

    // R8
    signed_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sub_en)) |->
            cmp_lt == ($signed($past(op_a)) < $signed($past(op_b))));

    // R8
    order_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sub_en)) |-> $countones({cmp_lt, cmp_eq, cmp_gt}) == 1);

    // R9
    unsigned_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sub_en)) |-> cmp_ltu == ($past(op_a) < $past(op_b)));
endmodule

// File: tb/sim_addsub_flags_unit.sv
`timescale 1ns/1ps
module sim_addsub_flags_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        bit z, n, c, v;
        bit [5:0] scmp;   // {lt,le,eq,ne,ge,gt}
        bit [3:0] ucmp;   // {ltu,leu,geu,gtu}
    } exp_t;

    // 32-bit instance
    logic [31:0] a0, b0, r0;
    logic s0, z0, n0, c0, v0;
    logic lt0, le0, eq0, ne0, ge0, gt0, ltu0, leu0, geu0, gtu0;
    // 4-bit instance
    logic [3:0] a4, b4, r4;
    logic s4, z4, n4, c4, v4;
    logic lt4, le4, eq4, ne4, ge4, gt4, ltu4, leu4, geu4, gtu4;

    addsub_flags_unit #(.WIDTH(32)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(a0), .op_b(b0), .sub_en(s0),
        .result(r0), .flag_z(z0), .flag_n(n0), .flag_c(c0), .flag_v(v0),
        .cmp_lt(lt0), .cmp_le(le0), .cmp_eq(eq0), .cmp_ne(ne0), .cmp_ge(ge0),
        .cmp_gt(gt0), .cmp_ltu(ltu0), .cmp_leu(leu0), .cmp_geu(geu0), .cmp_gtu(gtu0));

    addsub_flags_unit #(.WIDTH(4)) u4 (
        .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .sub_en(s4),
        .result(r4), .flag_z(z4), .flag_n(n4), .flag_c(c4), .flag_v(v4),
        .cmp_lt(lt4), .cmp_le(le4), .cmp_eq(eq4), .cmp_ne(ne4), .cmp_ge(ge4),
        .cmp_gt(gt4), .cmp_ltu(ltu4), .cmp_leu(leu4), .cmp_geu(geu4), .cmp_gtu(gtu4));

    // Behavioural reference from integer arithmetic
    function automatic exp_t model(int w, logic [63:0] a, logic [63:0] b, bit sub);
        exp_t e;
        logic [63:0] mask, bn, full;
        longint sa, sb, exact, lo, hi;
        bit lt, eq, gt, ltu, gtu;
        mask = (64'd1 << w) - 64'd1;
        a = a & mask;
        b = b & mask;
        bn = sub ? (~b & mask) : b;
        full = a + bn + {63'd0, sub};
        e.res = full & mask;
        e.c = full[w];
        sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
        sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
        exact = sub ? sa - sb : sa + sb;
        lo = -(longint'(1) << (w-1));
        hi = (longint'(1) << (w-1)) - 1;
        e.v = (exact < lo) || (exact > hi);
        e.z = (e.res == 64'd0);
        e.n = e.res[w-1];
        if (sub) begin
            lt = sa < sb; eq = (a == b); gt = sa > sb;
            ltu = a < b; gtu = a > b;
            e.scmp = {lt, lt | eq, eq, !eq, !lt, gt};
            e.ucmp = {ltu, ltu | eq, !ltu, gtu};
        end else begin
            lt = e.n ^ e.v;
            e.scmp = {lt, e.z | lt, e.z, !e.z, !lt, !(e.z | lt)};
            e.ucmp = {!e.c, !e.c | e.z, e.c, !(!e.c | e.z)};
        end
        return e;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_both(exp_t e0, bit sub0, exp_t e4, bit sub4);
        chk("R3", "u0 result", {32'd0, r0}, e0.res);
        chk("R4", "u0 zero", {63'd0, z0}, {63'd0, e0.z});
        chk("R5", "u0 neg", {63'd0, n0}, {63'd0, e0.n});
        chk("R6", "u0 carry", {63'd0, c0}, {63'd0, e0.c});
        chk("R7", "u0 ovf", {63'd0, v0}, {63'd0, e0.v});
        chk(sub0 ? "R8" : "R10", "u0 signed cmp",
            {58'd0, lt0, le0, eq0, ne0, ge0, gt0}, {58'd0, e0.scmp});
        chk(sub0 ? "R9" : "R10", "u0 unsigned cmp",
            {60'd0, ltu0, leu0, geu0, gtu0}, {60'd0, e0.ucmp});
        chk("R3", "u4 result", {60'd0, r4}, e4.res);
        chk("R4", "u4 zero", {63'd0, z4}, {63'd0, e4.z});
        chk("R5", "u4 neg", {63'd0, n4}, {63'd0, e4.n});
        chk("R6", "u4 carry", {63'd0, c4}, {63'd0, e4.c});
        chk("R7", "u4 ovf", {63'd0, v4}, {63'd0, e4.v});
        chk(sub4 ? "R8" : "R10", "u4 signed cmp",
            {58'd0, lt4, le4, eq4, ne4, ge4, gt4}, {58'd0, e4.scmp});
        chk(sub4 ? "R9" : "R10", "u4 unsigned cmp",
            {60'd0, ltu4, leu4, geu4, gtu4}, {60'd0, e4.ucmp});
    endtask

    // Drive at negedge, register at posedge, sample 1 ns later
    task automatic step(logic [31:0] xa, logic [31:0] xb, bit xs,
                        logic [3:0] ya, logic [3:0] yb, bit ys);
        exp_t e0, e4;
        @(negedge clk);
        a0 = xa; b0 = xb; s0 = xs;
        a4 = ya; b4 = yb; s4 = ys;
        e0 = model(32, {32'd0, xa}, {32'd0, xb}, xs);
        e4 = model(4, {60'd0, ya}, {60'd0, yb}, ys);
        @(posedge clk);
        #1;
        check_both(e0, xs, e4, ys);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        a0 = 32'hDEADBEEF; b0 = 32'h12345678; s0 = 1'b1;
        a4 = 4'hA; b4 = 4'h3; s4 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds every output at zero despite nonzero inputs
        chk("R1", "u0 outputs in reset",
            {18'd0, r0, z0, n0, c0, v0, lt0, le0, eq0, ne0, ge0, gt0, ltu0, leu0, geu0, gtu0}, 64'd0);
        chk("R1", "u4 outputs in reset",
            {46'd0, r4, z4, n4, c4, v4, lt4, le4, eq4, ne4, ge4, gt4, ltu4, leu4, geu4, gtu4}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed 32-bit corners
        step(32'hFFFFFFFF, 32'h00000001, 1'b0, 4'hF, 4'h1, 1'b0); // full ripple
        step(32'h00000001, 32'hFFFFFFFF, 1'b0, 4'h1, 4'hF, 1'b0); // 1 + (-1) sets C
        step(32'h80000000, 32'h00000001, 1'b1, 4'h8, 4'h1, 1'b1); // most negative - 1 sets V
        step(32'h7FFFFFFF, 32'h00000001, 1'b0, 4'h7, 4'h1, 1'b0); // add overflow
        step(32'h00000005, 32'h00000005, 1'b1, 4'h5, 4'h5, 1'b1); // equal
        step(32'h00000000, 32'h00000001, 1'b1, 4'h0, 4'h1, 1'b1); // borrow
        step(32'h80000000, 32'h7FFFFFFF, 1'b1, 4'h8, 4'h7, 1'b1);
        step(32'h80000000, 32'h80000000, 1'b0, 4'h8, 4'h8, 1'b0); // add to zero with V
        step(32'h00000000, 32'h00000000, 1'b0, 4'h0, 4'h0, 1'b0);

        // R2: new inputs do not reach the outputs before the next edge
        held = r0;
        @(negedge clk);
        a0 = 32'h00001234; b0 = 32'h00000011; s0 = 1'b0;
        #1;
        chk("R2", "u0 result before edge", {32'd0, r0}, {32'd0, held});
        @(posedge clk);
        #1;
        chk("R2", "u0 result after edge", {32'd0, r0}, 64'h0000_0000_0000_1245);

        // Exhaustive 4-bit, random 32-bit alongside
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    step($urandom, $urandom, bit'($urandom_range(0, 1)),
                         4'(i), 4'(j), bit'(s));
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule